// File: doc/BRIEF.md
# Quasi-Uniform LLR Message Quantizer

This block sits between the arithmetic of an iterative LDPC decoder and its message storage. It turns signed fixed-point log-likelihood ratios into short sign-magnitude message codes. It also turns such codes back into fixed-point values. Near zero the magnitude grid is uniform with a nominal step. Past a boundary level, each further level is the previous one multiplied by a growth factor greater than one. The same number of code bits therefore covers a much wider range than plain clipping would. The check-node and variable-node update rules are untouched, because only the representation of messages changes.

The block has two independent paths: a quantize path (fixed-point in, code out) and a dequantize path (code in, fixed-point out). Each path has a single registered output stage qualified by a valid flag. The step, the growth factor, the number of magnitude bits and the internal width are elaboration parameters. The level table is computed at elaboration. A parameter selects an alternate plain uniform mode, a signed fixed-point format with 2 fractional bits, for comparison.

Internal fixed-point values have 6 fractional bits. With the defaults (5 magnitude bits, step 16 LSB = 0.25, growth 1.3, 16-bit values), the boundary index is N = 15. This gives 31 distinct magnitude levels.

Top module: `llr_qu_quantizer`

## Requirements
- R1: A message code is MAG_BITS+1 bits wide. The top bit is the sign (1 = negative) and the lower MAG_BITS bits are a magnitude index k.
- R2: With N = 2^(MAG_BITS-1) - 1, index k < N reconstructs to k·STEP_LSB. Index k in N..2N reconstructs to N·STEP_LSB·(GROWTH_MILLI/1000)^(k-N), rounded to the nearest LSB and limited to the positive range. Indices above 2N decode as index 2N.
- R3: With UNIFORM = 1, every index k in 0..2^MAG_BITS-1 reconstructs to k·STEP_LSB. With the defaults this spans ±7.75 in steps of 0.25.
- R4: Quantization picks the level nearest to the input magnitude. A tie goes to the smaller index. Magnitudes beyond the top level give the top index.
- R5: A code whose magnitude index is 0 is produced with the sign bit cleared. A code with the sign set and index 0 dequantizes to 0.
- R6: Dequantization outputs the reconstruction level of the (clamped) index, negated when the sign bit is set.
- R7: Each path registers its result one clock after its input valid, raises its output valid in that same cycle, and holds its data while its input valid is low.
- R8: While rst_n is low at a clock edge, both output valids and both output data registers are cleared.
- R9: The two paths are independent; both may accept an input in the same cycle with no effect on each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_in_valid | input | 1 | Quantize input qualifier |
| q_in_llr | input | LLR_W | Signed fixed-point LLR, 6 fractional bits |
| q_out_valid | output | 1 | Quantize result valid |
| q_out_code | output | MAG_BITS+1 | Sign-magnitude message code |
| d_in_valid | input | 1 | Dequantize input qualifier |
| d_in_code | input | MAG_BITS+1 | Sign-magnitude message code |
| d_out_valid | output | 1 | Dequantize result valid |
| d_out_llr | output | LLR_W | Signed fixed-point reconstruction |

## Verification
The quantize and dequantize paths can each take an input in the same cycle. The bench drives both valids independently and at random over thousands of cycles, often both high at once. A behavioural model predicts each output every cycle, and any cross-talk between the paths shows up as a mismatch on one of them. A sweep over every code sends the dequantized value straight back through the quantize path and expects the canonical code. Directed cycles hit midpoint ties, saturation at both ends of the input range, negative zero, and reset asserted with valids high.

// File: rtl/llr_qq_pkg.sv
// Package: shared helpers for the quasi-uniform LLR quantizer.
// Assumes values carry FRAC_BITS fractional bits and levels fit LLR_W-1 bits.
package llr_qq_pkg;

    localparam int FRAC_BITS = 6;
    localparam int GROW_SHIFT = 20;

    // Boundary index N between uniform and geometric regions.
    function automatic int bound_index(input int mag_bits);
        return (1 << (mag_bits - 1)) - 1;
    endfunction

    // Highest distinct magnitude index for the selected mode.
    function automatic int top_index(input int mag_bits, input bit uniform);
        if (uniform)
            return (1 << mag_bits) - 1;
        return 2 * bound_index(mag_bits);
    endfunction

    // Reconstruction magnitude of index k, in LSB units, saturated to w-1 bits.
    function automatic longint level_of(input int k, input int mag_bits,
                                        input int step_lsb, input int growth_milli,
                                        input bit uniform, input int w);
        longint n;
        longint acc;
        longint v;
        longint lim;
        int kk;
        n   = longint'(bound_index(mag_bits));
        lim = (longint'(1) << (w - 1)) - 1;
        kk  = (k > top_index(mag_bits, uniform)) ? top_index(mag_bits, uniform) : k;
        if (uniform || longint'(kk) < n) begin
            v = longint'(kk) * longint'(step_lsb);
        end else begin
            acc = (n * longint'(step_lsb)) << GROW_SHIFT;
            for (int i = 0; i < kk - int'(n); i++) begin
                acc = (acc * longint'(growth_milli)) / 1000;
            end
            v = (acc + (longint'(1) << (GROW_SHIFT - 1))) >>> GROW_SHIFT;
        end
        if (v > lim)
            v = lim;
        return v;
    endfunction

endpackage

// File: rtl/llr_level_table.sv
// Level table: presents every reconstruction magnitude as a constant bus.
// Assumes parameters are legal (MAG_BITS >= 2, GROWTH_MILLI > 1000).
module llr_level_table #(
    parameter int MAG_BITS     = 5,
    parameter int LLR_W        = 16,
    parameter int STEP_LSB     = 16,
    parameter int GROWTH_MILLI = 1300,
    parameter bit UNIFORM      = 1'b0,
    localparam int TOP         = llr_qq_pkg::top_index(MAG_BITS, UNIFORM)
) (
    output logic [TOP:0][LLR_W-2:0] levels
);

    // One constant entry per distinct magnitude index.
    for (genvar k = 0; k <= TOP; k++) begin : g_lvl
        localparam longint LV = llr_qq_pkg::level_of(k, MAG_BITS, STEP_LSB,
                                                     GROWTH_MILLI, UNIFORM, LLR_W);
        assign levels[k] = (LLR_W-1)'(LV);
    end

endmodule

// File: rtl/llr_quantize.sv
// Quantize path: signed fixed-point LLR to sign-magnitude level code.
// Nearest level wins, ties go to the smaller index, overflow saturates.
// Assumes levels ascend strictly with index.
module llr_quantize #(
    parameter int MAG_BITS = 5,
    parameter int LLR_W    = 16,
    parameter bit UNIFORM  = 1'b0,
    localparam int TOP     = llr_qq_pkg::top_index(MAG_BITS, UNIFORM),
    localparam int CW      = MAG_BITS + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TOP:0][LLR_W-2:0]  levels,
    input  logic                     in_valid,
    input  logic [LLR_W-1:0]         in_llr,
    output logic                     out_valid,
    output logic [CW-1:0]            out_code
);

    logic                neg;
    logic [LLR_W-1:0]    mag;
    logic [TOP-1:0]      above;
    logic [MAG_BITS-1:0] idx;

    // Split the input into sign and unsigned magnitude.
    always_comb begin
        neg = in_llr[LLR_W-1];
        mag = neg ? (~in_llr + 1'b1) : in_llr;
    end

    // Threshold bank: bit k set when magnitude is strictly past midpoint k/k+1.
    for (genvar k = 0; k < TOP; k++) begin : g_cmp
        assign above[k] = {mag, 1'b0} >
                          ((LLR_W+1)'(levels[k]) + (LLR_W+1)'(levels[k+1]));
    end

    // Thermometer count gives the chosen index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < TOP; k++) begin
            idx = idx + MAG_BITS'(above[k]);
        end
    end

    // Output register with valid; data held when no input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_code <= {neg && (idx != '0), idx};
        end
    end

    assert_q_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_q_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_code));
    assert_q_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_code[MAG_BITS-1:0]) <= TOP));
    assert_q_no_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_code[CW-1] && out_code[MAG_BITS-1:0] == '0));
    assert_q_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_llr[LLR_W-1]) |=> !out_code[CW-1]);

endmodule

// File: rtl/llr_dequantize.sv
// Dequantize path: sign-magnitude level code to signed fixed-point value.
// Indices above the top level alias to it; negative zero yields zero.
module llr_dequantize #(
    parameter int MAG_BITS = 5,
    parameter int LLR_W    = 16,
    parameter bit UNIFORM  = 1'b0,
    localparam int TOP     = llr_qq_pkg::top_index(MAG_BITS, UNIFORM),
    localparam int CW      = MAG_BITS + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TOP:0][LLR_W-2:0]  levels,
    input  logic                     in_valid,
    input  logic [CW-1:0]            in_code,
    output logic                     out_valid,
    output logic [LLR_W-1:0]         out_llr
);

    localparam logic [MAG_BITS-1:0] TOP_K = MAG_BITS'(TOP);

    logic [MAG_BITS-1:0] kk;
    logic [LLR_W-1:0]    pos;
    logic [LLR_W-1:0]    val;

    // Clamp index, look up the level, apply the sign.
    always_comb begin
        kk  = (in_code[MAG_BITS-1:0] > TOP_K) ? TOP_K : in_code[MAG_BITS-1:0];
        pos = {1'b0, levels[kk]};
        val = in_code[CW-1] ? (~pos + 1'b1) : pos;
    end

    // Output register with valid; data held when no input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_llr   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_llr <= val;
        end
    end

    assert_d_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_d_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_llr));
    assert_d_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_code[CW-1]) |=> !out_llr[LLR_W-1]);
    assert_d_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_llr) <= $signed({1'b0, levels[TOP]}) &&
                       $signed(out_llr) >= -$signed({1'b0, levels[TOP]})));

endmodule

// File: rtl/llr_qu_quantizer.sv
// Top: quasi-uniform (or plain uniform) LLR message quantizer with
// independent registered quantize and dequantize paths sharing one level table.
// STEP_LSB is in units of 2^-6; GROWTH_MILLI is the growth factor times 1000.
module llr_qu_quantizer #(
    parameter int MAG_BITS     = 5,
    parameter int LLR_W        = 16,
    parameter int STEP_LSB     = 16,
    parameter int GROWTH_MILLI = 1300,
    parameter bit UNIFORM      = 1'b0,
    localparam int TOP         = llr_qq_pkg::top_index(MAG_BITS, UNIFORM),
    localparam int CW          = MAG_BITS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_in_valid,
    input  logic [LLR_W-1:0] q_in_llr,
    output logic             q_out_valid,
    output logic [CW-1:0]    q_out_code,
    input  logic             d_in_valid,
    input  logic [CW-1:0]    d_in_code,
    output logic             d_out_valid,
    output logic [LLR_W-1:0] d_out_llr
);

    logic [TOP:0][LLR_W-2:0] levels;

    llr_level_table #(
        .MAG_BITS(MAG_BITS), .LLR_W(LLR_W), .STEP_LSB(STEP_LSB),
        .GROWTH_MILLI(GROWTH_MILLI), .UNIFORM(UNIFORM)
    ) u_table (
        .levels(levels)
    );

    llr_quantize #(
        .MAG_BITS(MAG_BITS), .LLR_W(LLR_W), .UNIFORM(UNIFORM)
    ) u_quant (
        .clk(clk), .rst_n(rst_n), .levels(levels),
        .in_valid(q_in_valid), .in_llr(q_in_llr),
        .out_valid(q_out_valid), .out_code(q_out_code)
    );

    llr_dequantize #(
        .MAG_BITS(MAG_BITS), .LLR_W(LLR_W), .UNIFORM(UNIFORM)
    ) u_dequant (
        .clk(clk), .rst_n(rst_n), .levels(levels),
        .in_valid(d_in_valid), .in_code(d_in_code),
        .out_valid(d_out_valid), .out_llr(d_out_llr)
    );

endmodule

// File: tb/tb_llr_qu_quantizer.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model for a quasi-uniform and a uniform instance.
module tb_llr_qu_quantizer;

    localparam int Q  = 5;
    localparam int W  = 16;
    localparam int ST = 16;
    localparam int DM = 1300;
    localparam int CW = Q + 1;
    localparam int NC = 1 << Q;
    localparam int NB = (1 << (Q - 1)) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          qv;
    logic [W-1:0]  qllr;
    logic          dv;
    logic [CW-1:0] dcode;
    logic          q_ov [2];
    logic [CW-1:0] q_oc [2];
    logic          d_ov [2];
    logic [W-1:0]  d_ol [2];

    llr_qu_quantizer #(.MAG_BITS(Q), .LLR_W(W), .STEP_LSB(ST),
                       .GROWTH_MILLI(DM), .UNIFORM(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .q_in_valid(qv), .q_in_llr(qllr),
        .q_out_valid(q_ov[0]), .q_out_code(q_oc[0]),
        .d_in_valid(dv), .d_in_code(dcode),
        .d_out_valid(d_ov[0]), .d_out_llr(d_ol[0]));

    llr_qu_quantizer #(.MAG_BITS(Q), .LLR_W(W), .STEP_LSB(ST),
                       .GROWTH_MILLI(DM), .UNIFORM(1'b1)) dut_uni (
        .clk(clk), .rst_n(rst_n), .q_in_valid(qv), .q_in_llr(qllr),
        .q_out_valid(q_ov[1]), .q_out_code(q_oc[1]),
        .d_in_valid(dv), .d_in_code(dcode),
        .d_out_valid(d_ov[1]), .d_out_llr(d_ol[1]));

    int lv [2][NC];
    int top [2];
    int n_run = 0;
    int n_fail = 0;
    int e_qv [2];
    int e_qc [2];
    int e_dv [2];
    int e_dl [2];

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Nearest level by exhaustive search; strict improvement keeps the lower index.
    function automatic int ref_quant(input int m, input int llr);
        int mag = iabs(llr);
        int best = 0;
        int bd = iabs(mag - lv[m][0]);
        for (int k = 1; k <= top[m]; k++) begin
            if (iabs(mag - lv[m][k]) < bd) begin
                best = k;
                bd = iabs(mag - lv[m][k]);
            end
        end
        return (llr < 0 && best != 0) ? (best | NC) : best;
    endfunction

    function automatic int ref_deq(input int m, input int code);
        int k = code % NC;
        if (k > top[m]) k = top[m];
        return (code >= NC) ? -lv[m][k] : lv[m][k];
    endfunction

    function automatic int canon(input int m, input int code);
        int k = code % NC;
        if (k > top[m]) k = top[m];
        return (code >= NC && k != 0) ? (k | NC) : k;
    endfunction

    // One clock: drive, update model at the edge, compare at the falling edge.
    task automatic cyc(input string tag, input bit r, input bit a, input int llr,
                       input bit b, input int code);
        rst_n = r; qv = a; qllr = W'(llr); dv = b; dcode = CW'(code);
        @(posedge clk);
        for (int m = 0; m < 2; m++) begin
            if (!r) begin
                e_qv[m] = 0; e_qc[m] = 0; e_dv[m] = 0; e_dl[m] = 0;
            end else begin
                e_qv[m] = a;
                if (a) e_qc[m] = ref_quant(m, $signed(W'(llr)));
                e_dv[m] = b;
                if (b) e_dl[m] = ref_deq(m, code % (2 * NC));
            end
        end
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check({tag, " R7 quant valid"}, int'(q_ov[m]), e_qv[m]);
            check({tag, " R4 quant code"}, int'(q_oc[m]), e_qc[m]);
            check({tag, " R7 dequant valid"}, int'(d_ov[m]), e_dv[m]);
            check({tag, " R6 dequant value"}, int'($signed(d_ol[m])), e_dl[m]);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        real v;
        int rt;
        top[0] = 2 * NB;
        top[1] = NC - 1;
        for (int k = 0; k < NC; k++) begin
            lv[1][k] = k * ST;
            if (k < NB) begin
                lv[0][k] = k * ST;
            end else begin
                v = real'(NB * ST);
                for (int i = 0; i < k - NB; i++) v = v * (real'(DM) / 1000.0);
                lv[0][k] = int'($floor(v + 0.5));
                if (lv[0][k] > 32767) lv[0][k] = 32767;
            end
        end
        rst_n = 1'b0; qv = 1'b0; qllr = '0; dv = 1'b0; dcode = '0;
        @(negedge clk);

        // R8: reset with both valids high keeps outputs cleared.
        for (int i = 0; i < 3; i++) cyc("R8", 1'b0, 1'b1, 100, 1'b1, 5);
        check("R8 reset quant code", int'(q_oc[0]), 0);
        check("R8 reset dequant value", int'(d_ol[0]), 0);

        // R1: -3 steps gives sign plus index 3.
        cyc("R1", 1'b1, 1'b1, -48, 1'b0, 0);
        check("R1 sign-magnitude code", int'(q_oc[0]), 35);

        // R5: small negative rounds to zero with sign cleared; negative zero code.
        cyc("R5", 1'b1, 1'b1, -7, 1'b1, NC);
        check("R5 zero code sign", int'(q_oc[0]), 0);
        check("R5 negative zero value", int'($signed(d_ol[0])), 0);

        // R4: midpoint ties and just past them.
        cyc("R4", 1'b1, 1'b1, 8, 1'b0, 0);
        check("R4 tie low", int'(q_oc[0]), 0);
        cyc("R4", 1'b1, 1'b1, 9, 1'b0, 0);
        check("R4 past tie", int'(q_oc[0]), 1);
        cyc("R4", 1'b1, 1'b1, 232, 1'b0, 0);
        check("R4 tie at boundary", int'(q_oc[0]), 14);
        cyc("R4", 1'b1, 1'b1, -232, 1'b0, 0);
        check("R4 negative tie", int'(q_oc[0]), NC | 14);
        cyc("R4", 1'b1, 1'b1, 32767, 1'b0, 0);
        check("R4 saturate positive", int'(q_oc[0]), 2 * NB);
        check("R3 uniform saturate", int'(q_oc[1]), NC - 1);
        cyc("R4", 1'b1, 1'b1, -32768, 1'b0, 0);
        check("R4 saturate negative", int'(q_oc[0]), NC | (2 * NB));

        // R2: boundary, first geometric level, alias of spare index.
        cyc("R2", 1'b1, 1'b0, 0, 1'b1, NB);
        check("R2 boundary level", int'($signed(d_ol[0])), NB * ST);
        cyc("R2", 1'b1, 1'b0, 0, 1'b1, NB + 1);
        check("R2 first geometric level", int'($signed(d_ol[0])), lv[0][NB + 1]);
        cyc("R2", 1'b1, 1'b0, 0, 1'b1, NC - 1);
        check("R2 spare index alias", int'($signed(d_ol[0])), lv[0][2 * NB]);
        check("R3 uniform top level", int'($signed(d_ol[1])), (NC - 1) * ST);

        // R6: negative code.
        cyc("R6", 1'b1, 1'b0, 0, 1'b1, NC | 5);
        check("R6 negative level", int'($signed(d_ol[0])), -5 * ST);

        // R7: idle cycles hold data and drop valid.
        cyc("R7", 1'b1, 1'b0, 999, 1'b0, 3);
        cyc("R7", 1'b1, 1'b0, -999, 1'b0, 7);
        check("R7 hold dequant", int'($signed(d_ol[0])), -5 * ST);

        // Round trip of every code through both paths.
        for (int c = 0; c < 2 * NC; c++) begin
            cyc("R2", 1'b1, 1'b0, 0, 1'b1, c);
            for (int m = 0; m < 2; m++) begin
                rt = int'($signed(d_ol[m]));
                cyc("R2", 1'b1, 1'b1, rt, 1'b0, 0);
                check("R2 round trip", int'(q_oc[m]), canon(m, c));
            end
        end

        // R9: random traffic on both paths, often in the same cycle.
        for (int i = 0; i < 3000; i++) begin
            int llr;
            if (($urandom % 4) == 0) llr = int'($signed(16'($urandom)));
            else llr = int'($urandom % 26000) - 13000;
            cyc("R9", 1'b1, 1'($urandom % 3 != 0), llr,
                1'($urandom % 3 != 0), int'($urandom % (2 * NC)));
        end

        // R8: reset mid-run clears outputs.
        cyc("R8", 1'b0, 1'b1, 500, 1'b1, 9);
        cyc("R8", 1'b1, 1'b0, 0, 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule